// File: doc/BRIEF.md
# Burst Signal-Fail Monitor for Line Parity Errors

This block watches the line parity (B2) error count that a receive line-overhead processor produces once per frame. It declares or clears a Signal Fail (SF) condition. On each frame boundary it takes in one per-frame error count and keeps the counts of the most recent W frames in a circular history. It holds a running total of those W counts. SF is declared when that total reaches a programmable 16-bit threshold. SF clears when the total falls back below the threshold.

Software sees a small byte-wide register window. The threshold is written as a low byte and a high byte. The window length is given in frame periods. Two further registers hold a read-only SF status bit and a change-of-condition flag that clears when read, and one register holds an interrupt enable. Any write to the threshold or the window length wipes the history, the running total and the SF state, so that counts gathered under the old settings are never compared against the new ones.

Top module: `b2_burst_sf_mon`

## Requirements
- R1: The 16-bit threshold is written and read back as two bytes: address 0 holds bits 7:0 and address 1 holds bits 15:8. Both reset to 0.
- R2: Address 2 holds the window length in frames and reads back as written. Its reset value is 1. The value in use is 1 when the register holds 0, and DEPTH (default 64) when the register holds more than DEPTH.
- R3: On every clock edge where `frame_tick` is high, `frame_errs` is sampled. A value above MAX_ERR (default 24) is taken as MAX_ERR. The windowed total is the sum of the last W sampled counts, where W is the window length in use.
- R4: SF is set at the frame edge where the updated windowed total is greater than or equal to the threshold. SF appears on `sf_state` and as bit 4 of the read-only status register at address 3. The other bits of that register read 0.
- R5: SF is cleared at the frame edge where the updated windowed total is below the threshold.
- R6: SF does not change on a clock edge that carries neither a frame tick nor a configuration write, whatever `frame_errs` holds.
- R7: Every SF transition caused by a frame edge sets the change flag, which is bit 0 at address 4.
- R8: A read of address 4 returns the change flag and clears it on that edge. If an SF transition occurs on the same edge, the flag stays set.
- R9: `irq` is high exactly while the change flag and the enable bit (bit 0 at address 5) are both 1.
- R10: A write to address 0, 1 or 2, even with an unchanged value, empties the history, zeroes the total and clears SF without setting the change flag. Counts from before the write never count toward a later declaration.
- R11: Addresses 6 and 7 read 0. Writes to addresses 3 and 4 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| frame_errs | input | 5 | Parity error count for the frame just ended |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the change flag at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| sf_state | output | 1 | Current SF condition |
| irq | output | 1 | Interrupt request |

## Verification
The bench first feeds a count pattern whose total stays flat while the oldest entry drops out of the window. A design whose window is too long would then declare SF too early, and one whose window is too short would miss the later declaration. At the full 64-frame depth it checks that SF rises on exactly the 64th frame and falls on the 65th, which catches an off-by-one in the pointer wrap. Over-range counts are run against thresholds just above and just at the clamp value, so an unclamped design would declare where it must not. It also rewrites the threshold with an unchanged value after SF is up, so a design that kept stale history or raised the change flag on a configuration clear would show it.

// File: rtl/sf_pkg.sv
package sf_pkg;
   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] A_THR_LO = 3'd0;
   localparam logic [REG_AW-1:0] A_THR_HI = 3'd1;
   localparam logic [REG_AW-1:0] A_WLEN   = 3'd2;
   localparam logic [REG_AW-1:0] A_STAT   = 3'd3;
   localparam logic [REG_AW-1:0] A_ISTAT  = 3'd4;
   localparam logic [REG_AW-1:0] A_IEN    = 3'd5;
   localparam int SF_STAT_BIT = 4;
endpackage

// File: rtl/sf_cfg_regs.sv
module sf_cfg_regs
   import sf_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int LW    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [REG_AW-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              sf_q,
   input  logic              sf_evt,
   output logic [7:0]        rdata,
   output logic [15:0]       thr,
   output logic [LW-1:0]     win_len,
   output logic              cfg_clr,
   output logic              irq
);
   logic [7:0] thr_lo, thr_hi, wlen_raw;
   logic       int_stat, int_en;
   logic       rd_istat;

   assign thr      = {thr_hi, thr_lo};
   assign rd_istat = rd && (addr == A_ISTAT);
   assign cfg_clr  = wr && (addr == A_THR_LO || addr == A_THR_HI || addr == A_WLEN);
   assign irq      = int_stat & int_en;

   always_comb begin
      if (wlen_raw == 8'd0)
         win_len = LW'(1);
      else if (int'(wlen_raw) > DEPTH)
         win_len = LW'(DEPTH);
      else
         win_len = LW'(wlen_raw);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_lo   <= '0;
         thr_hi   <= '0;
         wlen_raw <= 8'd1;
         int_en   <= 1'b0;
      end else if (wr) begin
         case (addr)
            A_THR_LO: thr_lo   <= wdata;
            A_THR_HI: thr_hi   <= wdata;
            A_WLEN:   wlen_raw <= wdata;
            A_IEN:    int_en   <= wdata[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         int_stat <= 1'b0;
      else if (sf_evt)
         int_stat <= 1'b1;
      else if (rd_istat)
         int_stat <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_THR_LO: rdata = thr_lo;
         A_THR_HI: rdata = thr_hi;
         A_WLEN:   rdata = wlen_raw;
         A_STAT:   rdata[SF_STAT_BIT] = sf_q;
         A_ISTAT:  rdata[0] = int_stat;
         A_IEN:    rdata[0] = int_en;
         default:  rdata = '0;
      endcase
   end

   assert_evt_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sf_evt |=> int_stat);
   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_istat && !sf_evt) |=> !int_stat);
endmodule

// File: rtl/sf_window_sum.sv
module sf_window_sum #(
   parameter int DEPTH   = 64,
   parameter int CW      = 5,
   parameter int MAX_ERR = 24,
   parameter int LW      = 7,
   parameter int SUM_W   = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [CW-1:0]    cnt_in,
   input  logic [LW-1:0]    win_len,
   output logic [SUM_W-1:0] sum_q,
   output logic [SUM_W-1:0] sum_nx
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [CW-1:0] slots [DEPTH];
   logic [PW-1:0] wp;
   logic [CW-1:0] cnt_c;
   logic [CW-1:0] oldest;

   generate
      if ((1 << CW) - 1 > MAX_ERR) begin : g_clamp
         assign cnt_c = (int'(cnt_in) > MAX_ERR) ? CW'(MAX_ERR) : cnt_in;
      end else begin : g_pass
         assign cnt_c = cnt_in;
      end
   endgenerate

   assign oldest = slots[wp];
   assign sum_nx = sum_q - SUM_W'(oldest) + SUM_W'(cnt_c);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
         wp    <= '0;
         sum_q <= '0;
      end else if (clr) begin
         for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
         wp    <= '0;
         sum_q <= '0;
      end else if (tick) begin
         slots[wp] <= cnt_c;
         sum_q     <= sum_nx;
         wp        <= (int'(wp) == int'(win_len) - 1) ? '0 : wp + PW'(1);
      end
   end

   assert_sum_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sum_q) <= MAX_ERR * 32'(win_len));
   assert_clr_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sum_q == '0));
endmodule

// File: rtl/sf_decide.sv
module sf_decide #(
   parameter int SUM_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   input  logic [SUM_W-1:0] sum_nx,
   input  logic [15:0]      thr,
   output logic             sf_q,
   output logic             sf_evt
);
   logic reach;

   assign reach  = 32'(sum_nx) >= 32'(thr);
   assign sf_evt = tick && !clr && (reach != sf_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sf_q <= 1'b0;
      else if (clr)
         sf_q <= 1'b0;
      else if (tick)
         sf_q <= reach;
   end

   assert_sf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(sf_q));
   assert_clr_drops_sf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !sf_q);
endmodule

// File: rtl/b2_burst_sf_mon.sv
module b2_burst_sf_mon
   import sf_pkg::*;
#(
   parameter int DEPTH   = 64,
   parameter int CW      = 5,
   parameter int MAX_ERR = 24
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        frame_tick,
   input  logic [4:0]  frame_errs,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [2:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   output logic        sf_state,
   output logic        irq
);
   localparam int LW    = $clog2(DEPTH + 1);
   localparam int SUM_W = $clog2(DEPTH * MAX_ERR + 1);

   generate
      if (DEPTH < 2 || DEPTH > 255) begin : g_bad_depth
         $error("DEPTH must lie in 2..255");
      end
      if (CW != 5) begin : g_bad_cw
         $error("CW must match the 5-bit count port");
      end
      if (MAX_ERR < 1 || MAX_ERR > (1 << CW) - 1) begin : g_bad_max
         $error("MAX_ERR must fit in CW bits");
      end
   endgenerate

   logic [15:0]      thr;
   logic [LW-1:0]    win_len;
   logic             cfg_clr;
   logic             sf_evt;
   logic [SUM_W-1:0] sum_q, sum_nx;

   sf_cfg_regs #(.DEPTH(DEPTH), .LW(LW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .sf_q(sf_state), .sf_evt(sf_evt), .rdata(reg_rdata),
      .thr(thr), .win_len(win_len), .cfg_clr(cfg_clr), .irq(irq)
   );

   sf_window_sum #(.DEPTH(DEPTH), .CW(CW), .MAX_ERR(MAX_ERR), .LW(LW), .SUM_W(SUM_W)) u_win (
      .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .tick(frame_tick),
      .cnt_in(frame_errs), .win_len(win_len), .sum_q(sum_q), .sum_nx(sum_nx)
   );

   sf_decide #(.SUM_W(SUM_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .clr(cfg_clr), .tick(frame_tick),
      .sum_nx(sum_nx), .thr(thr), .sf_q(sf_state), .sf_evt(sf_evt)
   );

   assert_rise_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sf_state) |-> $past(frame_tick));
   assert_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sf_state) |-> ($past(frame_tick) || $past(cfg_clr)));
endmodule

// File: tb/sim_b2_burst_sf_mon.sv
module sim_b2_burst_sf_mon;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_tick = 1'b0;
   logic [4:0] frame_errs = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       sf_state, irq;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   b2_burst_sf_mon u0 (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .frame_errs(frame_errs),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .sf_state(sf_state), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic frame(input logic [4:0] n);
      @(negedge clk);
      frame_tick = 1'b1; frame_errs = n;
      @(negedge clk);
      frame_tick = 1'b0; frame_errs = '0;
   endtask

   task automatic setup(input int thr, input int wl);
      logic [7:0] d;
      wr(3'd2, 8'(wl));
      wr(3'd0, 8'(thr));
      wr(3'd1, 8'(thr >> 8));
      rd(3'd4, d);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      chk(sf_state == 1'b0, "R4 reset sf", int'(sf_state), 0);
      chk(irq == 1'b0, "R9 reset irq", int'(irq), 0);
      rd(3'd2, d); chk(d == 8'd1, "R2 reset wlen", d, 1);
      rd(3'd0, d); chk(d == 8'd0, "R1 reset thr lo", d, 0);
   endtask

   task automatic t_regs;
      logic [7:0] d;
      wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd2, 8'd200);
      rd(3'd0, d); chk(d == 8'hA5, "R1 thr lo", d, 8'hA5);
      rd(3'd1, d); chk(d == 8'h3C, "R1 thr hi", d, 8'h3C);
      rd(3'd2, d); chk(d == 8'd200, "R2 wlen readback", d, 200);
      wr(3'd3, 8'hFF); wr(3'd4, 8'hFF);
      rd(3'd3, d); chk(d == 8'h00, "R11 stat write ignored", d, 0);
      rd(3'd4, d); chk(d == 8'h00, "R11 istat write ignored", d, 0);
      rd(3'd6, d); chk(d == 8'h00, "R11 addr6 zero", d, 0);
      rd(3'd7, d); chk(d == 8'h00, "R11 addr7 zero", d, 0);
   endtask

   task automatic t_declare_clear;
      logic [7:0] d;
      wr(3'd5, 8'd1);
      setup(10, 4);
      frame(5'd3); frame(5'd3); frame(5'd3);
      chk(sf_state == 1'b0, "R4 below threshold", sf_state, 0);
      frame(5'd3);
      chk(sf_state == 1'b1, "R4 declare at 12>=10", sf_state, 1);
      rd(3'd3, d); chk(d == 8'h10, "R4 status bit4", d, 8'h10);
      chk(irq == 1'b1, "R9 irq on", irq, 1);
      rd(3'd4, d); chk(d == 8'h01, "R7 flag set", d, 1);
      chk(irq == 1'b0, "R8 read clears", irq, 0);
      frame(5'd0);
      chk(sf_state == 1'b0, "R5 clear at 9<10", sf_state, 0);
      rd(3'd4, d); chk(d == 8'h01, "R7 flag on clear", d, 1);
   endtask

   task automatic t_slide;
      setup(20, 3);
      frame(5'd10); frame(5'd0); frame(5'd0); frame(5'd10);
      chk(sf_state == 1'b0, "R3 oldest dropped", sf_state, 0);
      frame(5'd10);
      chk(sf_state == 1'b1, "R3 window of 3 reaches 20", sf_state, 1);
      @(negedge clk); frame_errs = 5'd31;
      repeat (3) @(negedge clk);
      frame_errs = '0;
      chk(sf_state == 1'b1, "R6 no tick no change", sf_state, 1);
   endtask

   task automatic t_clamp;
      setup(25, 1);
      frame(5'd31);
      chk(sf_state == 1'b0, "R3 clamp 31->24 <25", sf_state, 0);
      setup(24, 1);
      frame(5'd31);
      chk(sf_state == 1'b1, "R3 clamp 24>=24", sf_state, 1);
   endtask

   task automatic t_cfg_clear;
      logic [7:0] d;
      setup(8, 4);
      frame(5'd8);
      chk(sf_state == 1'b1, "R10 precondition", sf_state, 1);
      rd(3'd4, d);
      wr(3'd0, 8'd8);
      chk(sf_state == 1'b0, "R10 write clears sf", sf_state, 0);
      rd(3'd4, d); chk(d == 8'h00, "R10 no flag on cfg clear", d, 0);
      frame(5'd0);
      chk(sf_state == 1'b0, "R10 history gone", sf_state, 0);
   endtask

   task automatic t_wlen_edges;
      logic [7:0] d;
      setup(5, 0);
      frame(5'd5); frame(5'd0);
      chk(sf_state == 1'b0, "R2 zero means one frame", sf_state, 0);
      setup(64, 200);
      for (int i = 0; i < 63; i++) frame(5'd1);
      chk(sf_state == 1'b0, "R2 63 frames below", sf_state, 0);
      frame(5'd1);
      chk(sf_state == 1'b1, "R2 depth 64 reached", sf_state, 1);
      frame(5'd0);
      chk(sf_state == 1'b0, "R5 first drops out", sf_state, 0);
      rd(3'd4, d);
   endtask

   task automatic t_irq_enable;
      logic [7:0] d;
      wr(3'd5, 8'd0);
      setup(1, 1);
      frame(5'd2);
      chk(irq == 1'b0, "R9 masked", irq, 0);
      rd(3'd4, d); chk(d == 8'h01, "R9 flag set under mask", d, 1);
      wr(3'd5, 8'd1);
      chk(irq == 1'b0, "R9 flag cleared earlier", irq, 0);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = 3'd4; frame_tick = 1'b1; frame_errs = 5'd0;
      @(negedge clk);
      reg_rd = 1'b0; frame_tick = 1'b0;
      chk(irq == 1'b1, "R8 event beats read clear", irq, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_declare_clear();
      t_slide();
      t_clamp();
      t_cfg_clear();
      t_wlen_edges();
      t_irq_enable();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule